// File: doc/BRIEF.md
# Sleep-Mode Clock Domain Controller

This block decides which clock domains of a small microcontroller keep running while the processor sleeps. Five domains are controlled: the processor core, the general I/O peripherals, the analog-to-digital converter, the asynchronous timer and the main oscillator. Software picks one of six sleep depths through a 3-bit mode code. It arms sleep with an enable bit and then executes the sleep instruction, which arrives here as a one-cycle strobe.

On entry the controller latches the mode and drops the enables of every domain that the mode stops. It then waits for a wake source that the mode permits. A general pending interrupt wakes every mode. The asynchronous-timer interrupt wakes only the modes in which that timer still runs. On wake, all domains come back on the following cycle. Oscillator start-up delays and the gated logic itself lie outside the block.

Top module: `slp_clk_ctrl`

## Requirements
- R1: While reset is asserted, and after it, until the first sleep entry, all five enables are 1 and `sleeping` is 0. Assertion of `rst_n` takes effect without a clock edge.
- R2: A `sleep_strobe` sampled high at a clock edge together with `sleep_en` high, while awake, sets `sleeping` after that edge and latches the mode code sampled at the same edge.
- R3: A `sleep_strobe` sampled with `sleep_en` low has no effect: `sleeping` stays 0 and all enables stay 1.
- R4: While asleep the enables, written cpu/io/adc/tmr/osc, are: code 000 gives 0/1/1/1/1; 001 gives 0/0/1/1/1; 010 gives 0/0/0/0/0; 011 gives 0/0/0/1/0; 110 gives 0/0/0/0/1; 111 gives 0/0/0/1/1.
- R5: The unused mode codes 100 and 101 behave exactly like code 000.
- R6: `irq_pending` sampled high while asleep wakes the block in every mode.
- R7: `timer_irq` wakes the block in modes 000, 001, 011, 100, 101 and 111. In modes 010 and 110 it is ignored: `sleeping` and the enables keep their values.
- R8: After a wake edge, all enables are 1 and `sleeping` is 0 from that edge onward. Whenever `sleeping` is 0, every enable is 1.
- R9: While asleep and with no permitted wake source, changes on `mode_sel` and further strobes, with or without `sleep_en`, leave `sleeping` and all enables unchanged.
- R10: The processor clock enable is 0 whenever `sleeping` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_en | input | 1 | Arms sleep entry |
| sleep_strobe | input | 1 | One-cycle pulse from the sleep instruction |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| timer_irq | input | 1 | Interrupt from the asynchronous timer |
| cpu_clk_en | output | 1 | Processor core clock enable |
| io_clk_en | output | 1 | I/O peripheral clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| tmr_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| sleeping | output | 1 | Block is in a sleep mode |

## Verification
The properties assume that every input is synchronous to `clk` and settled at each rising edge. They also assume that reset is held long enough for the synchronizer to flush. Timer interrupts are only checked in modes where they are ignored when `irq_pending` is also low at that edge. The bench drives all inputs on falling edges and holds reset for several cycles. It sweeps all eight mode codes against each wake source, and pulses `timer_irq` alone so that the ignored case is seen in isolation.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int MODE_W  = 3;
  localparam int NUM_DOM = 5;

  // domain bit positions inside the enable vector
  localparam int DOM_OSC = 0;
  localparam int DOM_TMR = 1;
  localparam int DOM_ADC = 2;
  localparam int DOM_IO  = 3;
  localparam int DOM_CPU = 4;

  typedef enum logic [MODE_W-1:0] {
    SM_IDLE  = 3'b000,
    SM_ADCNR = 3'b001,
    SM_PDOWN = 3'b010,
    SM_PSAVE = 3'b011,
    SM_STBY  = 3'b110,
    SM_XSTBY = 3'b111
  } sleep_mode_e;

  typedef logic [NUM_DOM-1:0] dom_vec_t;

endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output sleep_mode_e       mode
);

  always_comb begin
    case (code)
      3'b001:  mode = SM_ADCNR;
      3'b010:  mode = SM_PDOWN;
      3'b011:  mode = SM_PSAVE;
      3'b110:  mode = SM_STBY;
      3'b111:  mode = SM_XSTBY;
      default: mode = SM_IDLE;  // 000 and the unused 100, 101
    endcase
  end

endmodule

// File: rtl/slp_wake_logic.sv
module slp_wake_logic
  import slp_pkg::*;
(
  input  sleep_mode_e mode,
  input  logic        irq_pending,
  input  logic        timer_irq,
  output logic        wake
);

  logic timer_alive;

  // the timer interrupt only counts where the timer keeps its clock
  always_comb begin
    case (mode)
      SM_PDOWN, SM_STBY: timer_alive = 1'b0;
      default:           timer_alive = 1'b1;
    endcase
  end

  assign wake = irq_pending | (timer_irq & timer_alive);

endmodule

// File: rtl/slp_domain_map.sv
module slp_domain_map
  import slp_pkg::*;
(
  input  sleep_mode_e mode,
  input  logic        asleep,
  output dom_vec_t    en
);

  dom_vec_t keep;

  always_comb begin
    keep = '0;
    case (mode)
      SM_IDLE: begin
        keep[DOM_IO]  = 1'b1;
        keep[DOM_ADC] = 1'b1;
        keep[DOM_TMR] = 1'b1;
        keep[DOM_OSC] = 1'b1;
      end
      SM_ADCNR: begin
        keep[DOM_ADC] = 1'b1;
        keep[DOM_TMR] = 1'b1;
        keep[DOM_OSC] = 1'b1;
      end
      SM_PSAVE: keep[DOM_TMR] = 1'b1;
      SM_STBY:  keep[DOM_OSC] = 1'b1;
      SM_XSTBY: begin
        keep[DOM_TMR] = 1'b1;
        keep[DOM_OSC] = 1'b1;
      end
      default:  keep = '0;  // deepest mode stops everything
    endcase
  end

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    assign en[i] = ~asleep | keep[i];
  end

endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              sleep_en,
  input  logic              sleep_strobe,
  input  logic              irq_pending,
  input  logic              timer_irq,
  output logic              cpu_clk_en,
  output logic              io_clk_en,
  output logic              adc_clk_en,
  output logic              tmr_clk_en,
  output logic              osc_en,
  output logic              sleeping
);

  logic        rst_sync_n;
  sleep_mode_e req_mode;
  sleep_mode_e mode_q, mode_d;
  logic        sleeping_q, sleeping_d;
  dom_vec_t    en_q, en_d;
  logic        wake;
  logic        en_upd;

  slp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  slp_mode_decode u_dec (
    .code (mode_sel),
    .mode (req_mode)
  );

  slp_wake_logic u_wake (
    .mode        (mode_q),
    .irq_pending (irq_pending),
    .timer_irq   (timer_irq),
    .wake        (wake)
  );

  slp_domain_map u_map (
    .mode   (mode_d),
    .asleep (sleeping_d),
    .en     (en_d)
  );

  // next state
  always_comb begin
    sleeping_d = sleeping_q;
    mode_d     = mode_q;
    if (!sleeping_q) begin
      if (sleep_strobe && sleep_en) begin
        sleeping_d = 1'b1;
        mode_d     = req_mode;
      end
    end else if (wake) begin
      sleeping_d = 1'b0;
    end
  end

  assign en_upd = sleeping_d ^ sleeping_q;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sleeping_q <= 1'b0;
      mode_q     <= SM_IDLE;
      en_q       <= '1;
    end else begin
      sleeping_q <= sleeping_d;
      if (en_upd) begin
        mode_q <= mode_d;
        en_q   <= en_d;
      end
    end
  end

  assign cpu_clk_en = en_q[DOM_CPU];
  assign io_clk_en  = en_q[DOM_IO];
  assign adc_clk_en = en_q[DOM_ADC];
  assign tmr_clk_en = en_q[DOM_TMR];
  assign osc_en     = en_q[DOM_OSC];
  assign sleeping   = sleeping_q;

  // ---------------- assertions ----------------
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleeping_q && sleep_strobe && sleep_en) |=> sleeping_q);

  p_disarmed_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sleeping_q && !(sleep_strobe && sleep_en)) |=> !sleeping_q);

  p_irq_wakes_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleeping_q && irq_pending) |=> !sleeping_q);

  p_timer_ignored_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleeping_q && !irq_pending && (mode_q == SM_PDOWN || mode_q == SM_STBY))
      |=> (sleeping_q && $stable(en_q)));

  p_awake_all_on_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sleeping_q |-> (en_q == '1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleeping_q && !wake) |=> (sleeping_q && $stable(en_q) && $stable(mode_q)));

  p_cpu_off_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sleeping_q |-> !en_q[DOM_CPU]);

endmodule

// File: tb/sim_slp_clk_ctrl.sv
module sim_slp_clk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic       sleep_en, sleep_strobe, irq_pending, timer_irq;
  logic       cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_en, sleeping;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;  // 250 MHz

  slp_clk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
    .sleep_strobe(sleep_strobe), .irq_pending(irq_pending), .timer_irq(timer_irq),
    .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .tmr_clk_en(tmr_clk_en), .osc_en(osc_en), .sleeping(sleeping)
  );

  // {sleeping, cpu, io, adc, tmr, osc}
  function automatic logic [5:0] observed();
    return {sleeping, cpu_clk_en, io_clk_en, adc_clk_en, tmr_clk_en, osc_en};
  endfunction

  // enables while asleep, per the mode table (R4, R5)
  function automatic logic [4:0] exp_keep(int c);
    case (c)
      1:       return 5'b00111;
      2:       return 5'b00000;
      3:       return 5'b00010;
      6:       return 5'b00001;
      7:       return 5'b00011;
      default: return 5'b01111;
    endcase
  endfunction

  function automatic logic timer_wakes(int c);
    return !(c == 2 || c == 6);
  endfunction

  task automatic check(string req, logic [5:0] exp);
    logic [5:0] act;
    act = observed();
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    sleep_en = 1'b0; sleep_strobe = 1'b0; irq_pending = 1'b0; timer_irq = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", 6'b011111);
    repeat (2) step();
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 after release", 6'b011111);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_sel = 3'b000;
    idle_inputs();
    repeat (3) step();
    check("R1 reset held", 6'b011111);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 after release", 6'b011111);

    for (int c = 0; c < 8; c++) begin
      for (int w = 0; w < 2; w++) begin
        logic [5:0] slp;
        slp = {1'b1, exp_keep(c)};

        // disarmed strobe
        mode_sel = 3'(c); sleep_en = 1'b0; sleep_strobe = 1'b1;
        step();
        sleep_strobe = 1'b0;
        step();
        check("R3", 6'b011111);

        // armed entry
        sleep_en = 1'b1; sleep_strobe = 1'b1;
        step();
        sleep_en = 1'b0; sleep_strobe = 1'b0;
        check((c == 4 || c == 5) ? "R5" : "R2/R4/R10", slp);

        // mode change and further strobes while asleep
        mode_sel = ~3'(c);
        step();
        sleep_en = 1'b1; sleep_strobe = 1'b1;
        step();
        sleep_strobe = 1'b0; sleep_en = 1'b0;
        step();
        check("R9", slp);

        if (w == 0) begin
          irq_pending = 1'b1;
          step();
          irq_pending = 1'b0;
          check("R6/R8", 6'b011111);
        end else begin
          timer_irq = 1'b1;
          step();
          timer_irq = 1'b0;
          check("R7", timer_wakes(c) ? 6'b011111 : slp);
          step();
          check("R7 after", timer_wakes(c) ? 6'b011111 : slp);
          if (!timer_wakes(c)) begin
            irq_pending = 1'b1;
            step();
            irq_pending = 1'b0;
            check("R6/R8", 6'b011111);
          end
        end
        step();
        check("R8 stays awake", 6'b011111);
      end
    end

    // reset while asleep in the deepest mode
    mode_sel = 3'b010; sleep_en = 1'b1; sleep_strobe = 1'b1;
    step();
    idle_inputs();
    check("R4 deepest", 6'b100000);
    do_reset();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule